// File: doc/BRIEF.md
# PCI host interrupt status controller

This block gathers the interrupt events of a PCI host bridge into one CPU interrupt line. Single-cycle event pulses from the inbound and outbound descriptor engines, a bus-abort pulse and the level-sensitive external INTA line each latch into a sticky status bit. Software clears a status bit by writing 1 to it. A per-source mask selects which latched sources may interrupt, and a global enable bit gates the CPU line.

The set of pending sources is status AND mask. The block reports the lowest-numbered pending source as a 5-bit index with a valid flag, so a dispatcher can service sources in a fixed priority order. A mask-and-acknowledge port masks one source and clears its status bit in a single cycle, which suits a level-triggered handler that must silence a source before it runs.

Registers are reached through a small word-addressed bus: a write strobe, a 2-bit word address, write data, and read data that follows the address with no delay.

Top module: `pcirq_ctrl`

## Requirements
- R1: After reset the status, mask and enable registers read zero, `cpu_irq` is low and `src_valid` is low.
- R2: An event pulse sets its status bit, and the bit stays set until cleared. Bit map: inbound done/ok/error/end-of-list are bits 0..3 (`in_evt[0..3]`), the same outbound events are bits 4..7 (`out_evt[0..3]`), inbound out-of-descriptors is bit 9, external INTA is bit 25, bus abort is bit 26.
- R3: A bus write to word address 0 clears each status bit written as 1 and leaves those written as 0 unchanged.
- R4: When a set event and a clear land on the same status bit in the same cycle, the bit ends set. While `ext_inta` stays high, status bit 25 is set again on every cycle.
- R5: `src_valid` is high exactly when status AND mask is non-zero, and `src_idx` is then the lowest index set in that AND.
- R6: `cpu_irq` is high exactly when enable bit 0 is 1 and status AND mask is non-zero.
- R7: A cycle with `ack_valid` high clears both the mask bit and the status bit that `ack_idx` selects. If a mask write occurs in the same cycle, the acknowledge still clears its bit.
- R8: Status and mask bits at unused positions (8, 10..24, 27..31) and enable bits 31..1 always read zero, and writes to them have no effect.
- R9: Read data follows `bus_addr` with no delay: 0 status, 1 mask, 2 enable, 3 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_evt | input | 4 | Inbound descriptor event pulses (done, ok, error, end-of-list) |
| out_evt | input | 4 | Outbound descriptor event pulses (done, ok, error, end-of-list) |
| in_ood | input | 1 | Inbound out-of-descriptors pulse |
| ext_inta | input | 1 | External INTA level |
| abort_evt | input | 1 | Bus abort pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data |
| ack_valid | input | 1 | Mask-and-acknowledge request |
| ack_idx | input | 5 | Source index to acknowledge |
| cpu_irq | output | 1 | CPU interrupt line |
| src_valid | output | 1 | A pending source exists |
| src_idx | output | 5 | Lowest pending source index |

## Verification
On every cycle, assertions check that a set event always leaves its status bit set, that a latched bit without a clear holds, that the reported index is pending with no lower pending bit, that `cpu_irq` implies a valid source and a set enable, and that an acknowledge always removes the mask bit. Only the bench scenarios show the write-one-to-clear selectivity, the read mux and its zeroed unused positions, the repeated setting by a held INTA level, and a priority order that changes as sources are cleared.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;
  localparam int NSRC   = 27;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  localparam int N_DESC_EVT = 4;
  localparam int POS_IN     = 0;
  localparam int POS_OUT    = 4;
  localparam int POS_OOD    = 9;
  localparam int POS_EXT    = 25;
  localparam int POS_ABORT  = 26;

  localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] A_EN   = 2'd2;

  function automatic logic [NSRC-1:0] impl_bits();
    logic [NSRC-1:0] m;
    m = '0;
    for (int i = 0; i < N_DESC_EVT; i++) begin
      m[POS_IN + i]  = 1'b1;
      m[POS_OUT + i] = 1'b1;
    end
    m[POS_OOD]   = 1'b1;
    m[POS_EXT]   = 1'b1;
    m[POS_ABORT] = 1'b1;
    return m;
  endfunction

  localparam logic [NSRC-1:0] IMPL_MASK = impl_bits();
endpackage

// File: rtl/pcirq_rst_sync.sv
module pcirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pcirq_status.sv
module pcirq_status
  import pcirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] stat
);
  logic [NSRC-1:0] stat_q;
  logic [NSRC-1:0] stat_d;
  logic            stat_en;

  always_comb begin
    stat_en = (|set_vec) | (|clr_vec);
    // set has priority over clear on the same bit
    stat_d  = ((stat_q & ~clr_vec) | set_vec) & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat = stat_q;

  // R4: a set event always leaves its bit set, clear or not
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & IMPL_MASK) != '0) |=> ((stat & $past(set_vec & IMPL_MASK)) == $past(set_vec & IMPL_MASK)));

  // R2: a latched bit with no clear stays latched
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~clr_vec) != '0) |=> ((stat & $past(stat & ~clr_vec)) == $past(stat & ~clr_vec)));
endmodule

// File: rtl/pcirq_regs.sv
module pcirq_regs
  import pcirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              ack_valid,
  input  logic [IDX_W-1:0]  ack_idx,
  output logic [NSRC-1:0]   mask,
  output logic              glb_en,
  output logic [NSRC-1:0]   ack_vec
);
  logic [NSRC-1:0] mask_q, mask_d;
  logic            en_q, en_d;
  logic            mask_we, en_we, mask_upd;

  always_comb begin
    ack_vec = '0;
    if (ack_valid && (int'(ack_idx) < NSRC))
      ack_vec[ack_idx] = 1'b1;
    mask_we  = bus_wr && (bus_addr == A_MASK);
    en_we    = bus_wr && (bus_addr == A_EN);
    mask_upd = mask_we | ack_valid;
    mask_d   = mask_we ? (bus_wdata[NSRC-1:0] & IMPL_MASK) : mask_q;
    mask_d   = mask_d & ~ack_vec;
    en_d     = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (mask_upd) mask_q <= mask_d;
      if (en_we)    en_q   <= en_d;
    end
  end

  assign mask   = mask_q;
  assign glb_en = en_q;

  // R7: acknowledge always removes the selected mask bit
  a_r7_ack_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && (int'(ack_idx) < NSRC)) |=> (mask[$past(ack_idx)] == 1'b0));

  // R8: unused mask positions never hold a one
  a_r8_mask_unused: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> ((mask & ~IMPL_MASK) == '0));
endmodule

// File: rtl/pcirq_prio.sv
module pcirq_prio
  import pcirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  pend,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  // R5: reported index is pending and no lower index is pending
  a_r5_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (pend[idx] && ((pend & ((NSRC'(1) << idx) - NSRC'(1))) == '0)));
  a_r5_none: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (pend == '0));
endmodule

// File: rtl/pcirq_ctrl.sv
module pcirq_ctrl
  import pcirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        in_evt,
  input  logic [3:0]        out_evt,
  input  logic              in_ood,
  input  logic              ext_inta,
  input  logic              abort_evt,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ack_valid,
  input  logic [IDX_W-1:0]  ack_idx,
  output logic              cpu_irq,
  output logic              src_valid,
  output logic [IDX_W-1:0]  src_idx
);
  logic            rst_sync_n;
  logic [NSRC-1:0] set_vec, clr_vec, ack_vec;
  logic [NSRC-1:0] stat, mask, pend;
  logic            glb_en;

  pcirq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < N_DESC_EVT; i++) begin
      set_vec[POS_IN + i]  = in_evt[i];
      set_vec[POS_OUT + i] = out_evt[i];
    end
    set_vec[POS_OOD]   = in_ood;
    set_vec[POS_EXT]   = ext_inta;
    set_vec[POS_ABORT] = abort_evt;
    clr_vec = ack_vec;
    if (bus_wr && (bus_addr == A_STAT))
      clr_vec = clr_vec | bus_wdata[NSRC-1:0];
    clr_vec = clr_vec & IMPL_MASK;
  end

  pcirq_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ack_valid(ack_valid), .ack_idx(ack_idx),
    .mask(mask), .glb_en(glb_en), .ack_vec(ack_vec)
  );

  pcirq_status u_stat (
    .clk(clk), .rst_n(rst_sync_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .stat(stat)
  );

  assign pend = stat & mask;

  pcirq_prio u_prio (
    .clk(clk), .rst_n(rst_sync_n), .pend(pend), .found(src_valid), .idx(src_idx)
  );

  assign cpu_irq = glb_en & src_valid;

  always_comb begin
    unique case (bus_addr)
      A_STAT:  bus_rdata = DATA_W'(stat);
      A_MASK:  bus_rdata = DATA_W'(mask);
      A_EN:    bus_rdata = DATA_W'(glb_en);
      default: bus_rdata = '0;
    endcase
  end

  // R6: the CPU line needs both the global enable and a pending source
  a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_irq |-> (glb_en && (pend != '0)));
  // R4: a held INTA level keeps its status bit latched on the next cycle
  a_r4_level: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ext_inta |=> stat[POS_EXT]);
endmodule

// File: tb/pcirq_ctrl_tb.sv
module pcirq_ctrl_tb;
  import pcirq_pkg::*;

  logic        clk;
  logic        rst_n;
  logic [3:0]  in_evt, out_evt;
  logic        in_ood, ext_inta, abort_evt;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        ack_valid;
  logic [4:0]  ack_idx;
  logic        cpu_irq, src_valid;
  logic [4:0]  src_idx;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model, built from the requirements
  localparam logic [31:0] USED = 32'h0600_02FF;
  logic [31:0] m_stat, m_mask;
  logic        m_en;

  typedef struct packed {
    logic [7:0]  req;
    logic [1:0]  addr;
    logic [31:0] rd;
    logic        irq;
    logic        vld;
    logic [4:0]  idx;
  } exp_t;
  exp_t q[$];

  pcirq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .in_evt(in_evt), .out_evt(out_evt),
    .in_ood(in_ood), .ext_inta(ext_inta), .abort_evt(abort_evt),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ack_valid(ack_valid), .ack_idx(ack_idx),
    .cpu_irq(cpu_irq), .src_valid(src_valid), .src_idx(src_idx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // driver: one clock of stimulus, model updated per requirements
  task automatic cyc(input logic [3:0] ie, input logic [3:0] oe, input logic ood,
                     input logic ext, input logic ab, input logic wr,
                     input logic [1:0] a, input logic [31:0] wd,
                     input logic ak, input logic [4:0] ai);
    logic [31:0] setv, clrv;
    @(negedge clk);
    in_evt = ie; out_evt = oe; in_ood = ood; ext_inta = ext; abort_evt = ab;
    bus_wr = wr; bus_addr = a; bus_wdata = wd; ack_valid = ak; ack_idx = ai;
    setv = {5'b0, ab, ext, 15'b0, ood, 1'b0, oe, ie};
    clrv = (wr && a == 2'd0) ? wd : 32'h0;
    if (ak) clrv[ai] = 1'b1;
    m_stat = ((m_stat & ~clrv) | setv) & USED;
    if (wr && a == 2'd1) m_mask = wd & USED;
    if (ak) m_mask[ai] = 1'b0;
    if (wr && a == 2'd2) m_en = wd[0];
    @(posedge clk);
    #1;
    in_evt = '0; out_evt = '0; in_ood = 0; abort_evt = 0;
    bus_wr = 0; ack_valid = 0;
  endtask

  task automatic idle(); cyc(4'h0, 4'h0, 1'b0, ext_inta, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 5'd0); endtask
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cyc(4'h0, 4'h0, 1'b0, ext_inta, 1'b0, 1'b1, a, d, 1'b0, 5'd0);
  endtask

  // driver: push an expected item computed from the model
  task automatic expect_at(input logic [7:0] rq, input logic [1:0] a);
    exp_t e;
    logic [31:0] pend;
    @(negedge clk);
    bus_addr = a;
    pend = m_stat & m_mask;
    e.req = rq; e.addr = a;
    e.rd = (a == 2'd0) ? m_stat : (a == 2'd1) ? m_mask : (a == 2'd2) ? {31'b0, m_en} : 32'h0;
    e.vld = (pend != 0);
    e.irq = m_en && e.vld;
    e.idx = 5'd0;
    for (int i = 26; i >= 0; i--) if (pend[i]) e.idx = 5'(i);
    q.push_back(e);
  endtask

  // monitor: compare queued items against the outputs
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (bus_rdata !== e.rd || cpu_irq !== e.irq || src_valid !== e.vld ||
            (e.vld && src_idx !== e.idx)) begin
          failures++;
          $display("FAIL R%0d addr=%0d: rdata=%h irq=%b vld=%b idx=%0d expected rdata=%h irq=%b vld=%b idx=%0d",
                   e.req, e.addr, bus_rdata, cpu_irq, src_valid, src_idx,
                   e.rd, e.irq, e.vld, e.idx);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_stat = 0; m_mask = 0; m_en = 0;
    in_evt = 0; out_evt = 0; in_ood = 0; ext_inta = 0; abort_evt = 0;
    bus_wr = 0; bus_addr = 0; bus_wdata = 0; ack_valid = 0; ack_idx = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);

    // R1: reset state
    expect_at(8'd1, 2'd0); expect_at(8'd1, 2'd1); expect_at(8'd1, 2'd2);
    // R2: inbound error pulse latches bit 2, masked so no irq
    cyc(4'b0100, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 5'd0);
    idle();
    expect_at(8'd2, 2'd0);
    // R8: mask and enable keep only used positions
    wr(2'd1, 32'hFFFF_FFFF);
    expect_at(8'd8, 2'd1);
    wr(2'd2, 32'hFFFF_FFFF);
    expect_at(8'd8, 2'd2);
    // R6 / R5: enabled, lowest pending is 2
    expect_at(8'd6, 2'd0);
    // R2: outbound ok (bit 5) and abort (bit 26)
    cyc(4'h0, 4'b0010, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0, 1'b0, 5'd0);
    expect_at(8'd2, 2'd0);
    // R3: clear bit 2 only; R5 next lowest is 5
    wr(2'd0, 32'h0000_0004);
    expect_at(8'd3, 2'd0);
    expect_at(8'd5, 2'd1);
    // R6: global enable off hides the line but not the index
    wr(2'd2, 32'h0);
    expect_at(8'd6, 2'd2);
    wr(2'd2, 32'h1);
    // R4: set and clear on bit 0 in one cycle, set wins
    cyc(4'b0001, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 32'h0000_0001, 1'b0, 5'd0);
    expect_at(8'd4, 2'd0);
    // R4: held INTA relatches after a clear
    cyc(4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 5'd0);
    wr(2'd0, 32'h0200_0000);
    idle();
    expect_at(8'd4, 2'd0);
    cyc(4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 5'd0);
    wr(2'd0, 32'h0200_0000);
    expect_at(8'd3, 2'd0);
    // R7: acknowledge source 0 while writing the mask in the same cycle
    cyc(4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 32'hFFFF_FFFF, 1'b1, 5'd0);
    expect_at(8'd7, 2'd1);
    expect_at(8'd7, 2'd0);
    // R8: unused status bit write ignored; unused mask bit reads zero
    wr(2'd0, 32'hF9FF_FD00);
    expect_at(8'd8, 2'd0);
    wr(2'd1, 32'h0800_0100);
    expect_at(8'd8, 2'd1);
    // R9: word address 3 reads zero
    expect_at(8'd9, 2'd3);
    // R2: out-of-descriptors pulse to bit 9
    wr(2'd1, 32'h0000_0200);
    cyc(4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 5'd0);
    expect_at(8'd2, 2'd0);
    // R7: acknowledge clears the only pending source
    cyc(4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b1, 5'd9);
    expect_at(8'd7, 2'd0);
    expect_at(8'd7, 2'd1);

    idle();
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule